// File: doc/BRIEF.md
# SIMD Lane Compare Mask Unit

This unit takes two 128-bit vector operands and compares them element by element. Each element of the result becomes a mask: all ones where the chosen condition holds, all zeros where it does not. The element width is picked per operation from 8, 16, 32 or 64 bits. Signed relations, unsigned relations and a bit-test are available. The second operand can be swapped for the constant zero.

Three result forms exist. A full 128-bit vector form uses every element. A 64-bit vector form uses only the low half and clears the high half. A scalar form uses only element 0 and clears everything above it. Operations arrive already decoded on a valid/ready input channel. Each result is registered and handed out on a valid/ready output channel. Combinations that have no meaning are reported with an error flag instead of a result.

Top module: `simd_lane_cmp`

## Requirements
- R1: `in_size` code s (0..3) selects an element width of 8<<s bits. The number of elements in a vector form is the register byte count (16 for the full form, 8 for the 64-bit form) shifted right by s.
- R2: Every element of the result is either all ones (condition holds) or all zeros (condition fails). Every result byte is therefore 8'h00 or 8'hFF.
- R3: Op codes 0 equal, 1 greater-or-equal, 2 greater-than, 3 less-or-equal and 4 less-than compare the elements as two's-complement signed integers, with the first operand on the left.
- R4: Op codes 5 higher and 6 higher-or-same compare the elements as unsigned integers.
- R5: Op code 7 (bit-test) sets the element mask when the bitwise AND of the two elements is nonzero.
- R6: With `in_zero_src` = 1, each first-operand element is compared against zero and `in_b` is ignored.
- R7: With `in_scalar` = 1, only element 0 is evaluated and every result bit above that element is zero. `in_half` has no effect in this form.
- R8: With `in_half` = 1 and `in_scalar` = 0, bits 127..64 of the result are zero.
- R9: A result appears on `out_data` in the cycle after its input is accepted (`in_valid` and `in_ready`). `out_valid`, `out_data` and `out_err` hold steady until `out_ready` is seen. `in_ready` is high whenever the output register is empty or is being drained.
- R10: Two combinations are illegal: element size code 3 in the 64-bit vector form, and bit-test with the zero operand. For either one the beat is delivered with `out_err` = 1 and `out_data` = 0.
- R11: After reset, `out_valid` = 0, `out_err` = 0, `out_data` = 0 and `in_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be accepted |
| in_op | input | 3 | Comparison code (R3 to R5) |
| in_size | input | 2 | Element size code |
| in_zero_src | input | 1 | Compare against zero instead of `in_b` |
| in_scalar | input | 1 | Scalar form, element 0 only |
| in_half | input | 1 | 64-bit register form |
| in_a | input | 128 | First operand |
| in_b | input | 128 | Second operand |
| out_valid | output | 1 | Result held in output register |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 128 | Per-element mask vector |
| out_err | output | 1 | Illegal combination flag |

## Verification
A wrong lane-bank selection or a wrong element boundary shows up on the very next output beat. It appears as a result byte that breaks the element pattern, or that differs from a model which rebuilds each element with integer arithmetic. A faulty clear mask leaves nonzero bytes above the active element count on the first scalar or 64-bit beat. A faulty handshake register either loses or repeats a beat, or changes data while `out_ready` is low. The model's queue and the hold check catch that within one cycle of the stall.

// File: rtl/lcm_pkg.sv
`timescale 1ns/1ps
package lcm_pkg;
   typedef enum logic [2:0] {
      CMP_EQ  = 3'd0,
      CMP_GE  = 3'd1,
      CMP_GT  = 3'd2,
      CMP_LE  = 3'd3,
      CMP_LT  = 3'd4,
      CMP_HI  = 3'd5,
      CMP_HS  = 3'd6,
      CMP_TST = 3'd7
   } cmp_op_e;

   localparam int unsigned NUM_SIZES = 4;
endpackage

// File: rtl/lcm_lane.sv
`timescale 1ns/1ps
module lcm_lane
   import lcm_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  cmp_op_e      op,
   output logic [W-1:0] mask
);
   logic hit;

   always_comb begin
      unique case (op)
         CMP_EQ:  hit = (a == b);
         CMP_GE:  hit = ($signed(a) >= $signed(b));
         CMP_GT:  hit = ($signed(a) >  $signed(b));
         CMP_LE:  hit = ($signed(a) <= $signed(b));
         CMP_LT:  hit = ($signed(a) <  $signed(b));
         CMP_HI:  hit = (a >  b);
         CMP_HS:  hit = (a >= b);
         default: hit = |(a & b);
      endcase
   end

   assign mask = {W{hit}};
endmodule

// File: rtl/lcm_bank.sv
`timescale 1ns/1ps
module lcm_bank
   import lcm_pkg::*;
#(
   parameter int unsigned VEC_BYTES = 16,
   localparam int unsigned VEC_W = VEC_BYTES * 8
) (
   input  logic [VEC_W-1:0]                a,
   input  logic [VEC_W-1:0]                b,
   input  logic                            zero_src,
   input  cmp_op_e                         op,
   output logic [NUM_SIZES-1:0][VEC_W-1:0] res
);
   logic [VEC_W-1:0] b_eff;

   assign b_eff = zero_src ? '0 : b;

   for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
      localparam int unsigned EW    = 8 << s;
      localparam int unsigned LANES = VEC_BYTES >> s;
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         lcm_lane #(.W(EW)) u_lane (
            .a    (a[l*EW +: EW]),
            .b    (b_eff[l*EW +: EW]),
            .op   (op),
            .mask (res[s][l*EW +: EW])
         );
      end
   end
endmodule

// File: rtl/lcm_keep.sv
`timescale 1ns/1ps
module lcm_keep #(
   parameter int unsigned VEC_BYTES = 16,
   localparam int unsigned VEC_W = VEC_BYTES * 8,
   localparam int unsigned CNT_W = $clog2(VEC_BYTES) + 1
) (
   input  logic [1:0]       size,
   input  logic             scalar,
   input  logic             half,
   output logic [VEC_W-1:0] keep
);
   logic [CNT_W-1:0] keep_bytes;

   always_comb begin
      if (scalar)    keep_bytes = CNT_W'(1) << size;
      else if (half) keep_bytes = CNT_W'(VEC_BYTES / 2);
      else           keep_bytes = CNT_W'(VEC_BYTES);
   end

   for (genvar i = 0; i < VEC_BYTES; i++) begin : g_byte
      assign keep[i*8 +: 8] = {8{CNT_W'(i) < keep_bytes}};
   end
endmodule

// File: rtl/simd_lane_cmp.sv
`timescale 1ns/1ps
module simd_lane_cmp
   import lcm_pkg::*;
#(
   parameter int unsigned VEC_BYTES = 16,
   localparam int unsigned VEC_W  = VEC_BYTES * 8,
   localparam int unsigned HALF_W = VEC_W / 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [2:0]       in_op,
   input  logic [1:0]       in_size,
   input  logic             in_zero_src,
   input  logic             in_scalar,
   input  logic             in_half,
   input  logic [VEC_W-1:0] in_a,
   input  logic [VEC_W-1:0] in_b,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [VEC_W-1:0] out_data,
   output logic             out_err
);
   if (VEC_BYTES < 8 || (VEC_BYTES & (VEC_BYTES - 1)) != 0) begin : g_bad_cfg
      $error("VEC_BYTES must be a power of two of at least 8");
   end

   cmp_op_e                          op;
   logic [NUM_SIZES-1:0][VEC_W-1:0] bank;
   logic [VEC_W-1:0]                keep;
   logic [VEC_W-1:0]                result;
   logic                            legal;
   logic                            acc;

   assign op = cmp_op_e'(in_op);

   lcm_bank #(.VEC_BYTES(VEC_BYTES)) u_bank (
      .a        (in_a),
      .b        (in_b),
      .zero_src (in_zero_src),
      .op       (op),
      .res      (bank)
   );

   lcm_keep #(.VEC_BYTES(VEC_BYTES)) u_keep (
      .size   (in_size),
      .scalar (in_scalar),
      .half   (in_half),
      .keep   (keep)
   );

   assign legal  = !((in_half && !in_scalar && in_size == 2'd3) ||
                     (op == CMP_TST && in_zero_src));
   assign result = legal ? (bank[in_size] & keep) : '0;

   assign in_ready = !out_valid || out_ready;
   assign acc      = in_valid && in_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         out_err   <= 1'b0;
      end else if (acc) begin
         out_valid <= 1'b1;
         out_data  <= result;
         out_err   <= !legal;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end

   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_err)); // R9

   AST_HALF_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
      acc && in_half && !in_scalar |=> out_data[VEC_W-1:HALF_W] == '0); // R8

   AST_SCALAR_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
      acc && in_scalar && in_size == 2'd0 |=> out_data[VEC_W-1:8] == '0); // R7

   AST_ERR_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_err |-> out_data == '0); // R10

   for (genvar i = 0; i < VEC_BYTES; i++) begin : g_chk
      AST_MASK_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid |-> (out_data[i*8 +: 8] == 8'h00 || out_data[i*8 +: 8] == 8'hFF)); // R2
   end
endmodule

// File: tb/tb_simd_lane_cmp.sv
`timescale 1ns/1ps
module tb_simd_lane_cmp;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic         in_ready;
   logic [2:0]   in_op = '0;
   logic [1:0]   in_size = '0;
   logic         in_zero_src = 1'b0;
   logic         in_scalar = 1'b0;
   logic         in_half = 1'b0;
   logic [127:0] in_a = '0;
   logic [127:0] in_b = '0;
   logic         out_valid;
   logic         out_ready = 1'b1;
   logic [127:0] out_data;
   logic         out_err;

   int compared = 0;
   int mismatched = 0;
   bit backpress = 1'b0;
   bit mon_on = 1'b0;

   typedef struct {
      logic [127:0] data;
      logic         err;
      string        tag;
   } exp_t;
   exp_t q[$];

   bit           held_pend = 1'b0;
   logic [127:0] held_data;
   logic         held_err;

   always #2 clk = ~clk;

   simd_lane_cmp dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_op(in_op), .in_size(in_size), .in_zero_src(in_zero_src),
      .in_scalar(in_scalar), .in_half(in_half), .in_a(in_a), .in_b(in_b),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .out_err(out_err)
   );

   // Behavioural model: integer arithmetic per element
   function automatic exp_t model(input int op, input int sz, input bit zs,
                                  input bit sc, input bit hf,
                                  input logic [127:0] a, input logic [127:0] b);
      exp_t e;
      int w, n;
      e.data = '0;
      e.err  = 1'b0;
      e.tag  = "";
      if ((hf && !sc && sz == 3) || (op == 7 && zs)) begin
         e.err = 1'b1;
         return e;
      end
      w = 8 << sz;
      n = sc ? 1 : ((hf ? 8 : 16) >> sz);
      for (int l = 0; l < n; l++) begin
         longint unsigned ua, ub;
         longint sa, sb;
         bit h;
         ua = 64'(a >> (l*w));
         ub = zs ? 64'd0 : 64'(b >> (l*w));
         if (w < 64) begin
            ua = ua & ((64'd1 << w) - 1);
            ub = ub & ((64'd1 << w) - 1);
         end
         sa = longint'(ua << (64-w)) >>> (64-w);
         sb = longint'(ub << (64-w)) >>> (64-w);
         case (op)
            0: h = (sa == sb);
            1: h = (sa >= sb);
            2: h = (sa >  sb);
            3: h = (sa <= sb);
            4: h = (sa <  sb);
            5: h = (ua >  ub);
            6: h = (ua >= ub);
            default: h = ((ua & ub) != 0);
         endcase
         if (h)
            for (int k = 0; k < w; k++) e.data[l*w + k] = 1'b1;
      end
      return e;
   endfunction

   always @(negedge clk) out_ready <= backpress ? 1'($urandom % 2) : 1'b1;

   always @(negedge clk) begin
      #1.5;
      if (mon_on) begin
         if (held_pend) begin
            compared++;
            if (!out_valid || out_data !== held_data || out_err !== held_err) begin
               mismatched++;
               $display("FAIL R9 hold: valid=%b data=%h err=%b expected data=%h err=%b",
                        out_valid, out_data, out_err, held_data, held_err);
            end
         end
         held_pend = out_valid && !out_ready;
         held_data = out_data;
         held_err  = out_err;
         if (out_valid && out_ready) begin
            compared++;
            if (q.size() == 0) begin
               mismatched++;
               $display("FAIL R9 unexpected beat: data=%h expected none", out_data);
            end else begin
               exp_t e;
               e = q.pop_front();
               if (out_data !== e.data || out_err !== e.err) begin
                  mismatched++;
                  $display("FAIL %s: data=%h err=%b expected data=%h err=%b",
                           e.tag, out_data, out_err, e.data, e.err);
               end
            end
         end
      end
   end

   task automatic send(input int op, input int sz, input bit zs, input bit sc,
                       input bit hf, input logic [127:0] a, input logic [127:0] b,
                       input string tag);
      exp_t e;
      @(negedge clk);
      in_op = 3'(op); in_size = 2'(sz); in_zero_src = zs;
      in_scalar = sc; in_half = hf; in_a = a; in_b = b; in_valid = 1'b1;
      #1;
      while (!in_ready) begin
         @(negedge clk);
         #1;
      end
      e = model(op, sz, zs, sc, hf, a, b);
      e.tag = tag;
      q.push_back(e);
      @(posedge clk);
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   function automatic logic [127:0] rnd128();
      return {$urandom, $urandom, $urandom, $urandom};
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      logic [127:0] a, b;
      repeat (3) @(posedge clk);
      @(negedge clk);
      #1;
      // R11 reset state
      compared++;
      if (out_valid !== 1'b0 || out_err !== 1'b0 || out_data !== '0 || in_ready !== 1'b1) begin
         mismatched++;
         $display("FAIL R11: valid=%b err=%b data=%h ready=%b expected 0 0 0 1",
                  out_valid, out_err, out_data, in_ready);
      end
      rst_n = 1'b1;
      mon_on = 1'b1;

      // R3 equality on bytes, mixed match/mismatch
      a = 128'h00112233_44556677_8899AABB_CCDDEEFF;
      b = 128'h00112200_44556677_0099AABB_CCDDEE00;
      send(0, 0, 0, 0, 0, a, b, "R3 eq size0");
      // R3 signed relations on 16-bit elements with negative values
      a = 128'h8000_7FFF_FFFF_0001_0000_1234_FFFE_8001;
      b = 128'h7FFF_8000_0001_FFFF_0000_1234_FFFF_8000;
      send(1, 1, 0, 0, 0, a, b, "R3 ge size1");
      send(2, 1, 0, 0, 0, a, b, "R3 gt size1");
      send(3, 1, 0, 0, 0, a, b, "R3 le size1");
      send(4, 1, 0, 0, 0, a, b, "R3 lt size1");
      // R4 unsigned on 32-bit elements with top bit set
      a = 128'h80000000_00000001_FFFFFFFF_12345678;
      b = 128'h7FFFFFFF_00000001_00000000_12345679;
      send(5, 2, 0, 0, 0, a, b, "R4 hi size2");
      send(6, 2, 0, 0, 0, a, b, "R4 hs size2");
      // R5 bit-test on 64-bit elements
      a = 128'hF0F0F0F0_00000000_00000000_00000001;
      b = 128'h0F0F0F0F_FFFFFFFF_FFFFFFFF_00000001;
      send(7, 3, 0, 0, 0, a, b, "R5 tst size3");
      // R6 zero operand: b is garbage and must be ignored
      a = 128'h80_7F_00_01_FF_00_10_90_00_00_01_FF_80_7F_00_05;
      send(4, 0, 1, 0, 0, a, rnd128(), "R6 lt zero");
      send(0, 0, 1, 0, 0, a, rnd128(), "R6 eq zero");
      send(2, 2, 1, 0, 0, a, rnd128(), "R6 gt zero size2");
      // R7 scalar: only element 0, half ignored
      a = '1; b = '1;
      send(0, 2, 0, 1, 0, a, b, "R7 scalar size2");
      send(0, 3, 0, 1, 1, a, b, "R7 scalar half size3");
      send(6, 0, 0, 1, 0, a, b, "R7 scalar size0");
      // R8 64-bit form clears upper half
      send(0, 1, 0, 0, 1, a, b, "R8 half size1");
      send(6, 0, 0, 0, 1, a, b, "R8 half size0");
      // R1 element widths and counts on all-equal vectors
      for (int s = 0; s < 4; s++) send(0, s, 0, 0, 0, a, b, "R1 full width");
      // R10 illegal combinations
      send(0, 3, 0, 0, 1, a, b, "R10 half size3");
      send(7, 1, 1, 0, 0, a, b, "R10 tst zero");
      send(0, 0, 0, 0, 0, a, b, "R10 recovery");
      idle();

      // R9 under backpressure with random traffic
      backpress = 1'b1;
      for (int i = 0; i < 400; i++) begin
         a = rnd128();
         b = ($urandom % 2) ? (a ^ (rnd128() & rnd128() & rnd128())) : rnd128();
         send($urandom % 8, $urandom % 4, ($urandom % 5) == 0, ($urandom % 4) == 0,
              ($urandom % 3) == 0, a, b, "R9 random");
         if ($urandom % 4 == 0) idle();
      end
      idle();
      backpress = 1'b0;
      repeat (20) @(posedge clk);
      compared++;
      if (q.size() != 0 || out_valid !== 1'b0) begin
         mismatched++;
         $display("FAIL R9 drain: pending=%0d valid=%b expected 0 0", q.size(), out_valid);
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule